// File: doc/BRIEF.md
# Chainable Serial-Load Latched Sink-Switch Controller

This block holds the control logic of a serial-loaded bank of low-side switches. Bits arrive one at a time on a serial data pin and move through a shift chain, one position per rising edge of a shift strobe. A separate load strobe copies the whole chain into a storage register in one step. The storage register alone drives the switch controls, so a new pattern can be shifted in while the old one stays on the outputs.

Each output is a pair. A pull-down enable is set when its stored bit is 1. A release flag is set when the pin floats, which happens when the stored bit is 0 or when the bank is disabled. The disable input floats every pin but leaves the stored pattern in place. The clear input empties only the shift chain. The last chain stage appears on a serial output, so several eight-bit banks can be chained. A parameter sets how many banks one instance models.

Both strobes are sampled on the system clock, and an action happens only on a low-to-high change of the sampled strobe.

Top module: `latched_sink_driver`

## Requirements
- R1: On each cycle where `sclk_i` is high and was low in the previous cycle, the chain shifts up one position. `ser_i` enters bit 0, and bit k moves to bit k+1 across all 8×NUM_DEV bits. Bank d holds bits 8d..8d+7.
- R2: On each cycle where `rclk_i` rises, the storage register takes the whole chain. Otherwise the storage register holds its value, whatever happens on `sclk_i`, `ser_i` or `clr_ni`.
- R3: While `oe_ni` is 1, every `hiz_o` bit is 1 and every `drive_low_o` bit is 0. The storage register keeps its value and reappears when `oe_ni` returns to 0.
- R4: `clr_ni` low zeroes the shift chain at once, without waiting for a clock edge. The storage register is not changed.
- R5: `ser_o` equals the top chain bit, 8×NUM_DEV−1. After 8×NUM_DEV shifts, the first bit shifted in sits on that top bit.
- R6: With `oe_ni` at 0, a stored 1 in bit i gives `drive_low_o[i]`=1 and `hiz_o[i]`=0. A stored 0 gives `drive_low_o[i]`=0 and `hiz_o[i]`=1.
- R7: When both strobes rise in the same cycle, the storage register takes the chain contents from before that cycle's shift.
- R8: A strobe held high for many cycles acts only once.
- R9: After `rst_ni` the chain and the storage register are zero. So `drive_low_o` is all 0, `hiz_o` is all 1 and `ser_o` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock that samples the strobes |
| rst_ni | input | 1 | Active-low asynchronous reset of all state |
| sclk_i | input | 1 | Shift strobe; acts on its rising edge |
| rclk_i | input | 1 | Load strobe; acts on its rising edge |
| ser_i | input | 1 | Serial data into chain bit 0 |
| clr_ni | input | 1 | Active-low asynchronous clear of the shift chain only |
| oe_ni | input | 1 | Active-low output enable; 1 floats all pins |
| ser_o | output | 1 | Top chain bit, for chaining to the next bank |
| drive_low_o | output | 8×NUM_DEV | Pull-down enable per pin |
| hiz_o | output | 8×NUM_DEV | Release flag per pin |

## Verification
The bench builds the block with NUM_DEV=2, which gives a 16-bit chain made of two banks. With two banks it can check that a bit leaving the top of the first bank enters bank two, and that the first of sixteen bits shifted in lands on the top bit of the far bank. It also observes `ser_o` both after a full 16-shift load and one shift later. Word patterns that differ between the two bytes expose any swap of bank order or bit order.

// File: rtl/sink_drv_pkg.sv
package sink_drv_pkg;
  parameter int unsigned DEV_BITS = 8;
endpackage

// File: rtl/sink_drv_edge.sv
module sink_drv_edge (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic lvl_i,
  output logic rise_o
);
  logic lvl_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) lvl_q <= 1'b0;
    else         lvl_q <= lvl_i;
  end

  assign rise_o = lvl_i & ~lvl_q;
endmodule

// File: rtl/sink_drv_stage.sv
module sink_drv_stage #(
  parameter int unsigned W = 8
) (
  input  logic         clk_i,
  input  logic         arst_ni,
  input  logic         shift_i,
  input  logic         ser_i,
  output logic [W-1:0] q_o,
  output logic         ser_o
);
  logic [W-1:0] q;

  always_ff @(posedge clk_i or negedge arst_ni) begin
    if (!arst_ni)     q <= '0;
    else if (shift_i) q <= {q[W-2:0], ser_i};
  end

  assign q_o   = q;
  assign ser_o = q[W-1];
endmodule

// File: rtl/sink_drv_store.sv
module sink_drv_store #(
  parameter int unsigned W = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         load_i,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     q_o <= '0;
    else if (load_i) q_o <= d_i;
  end
endmodule

// File: rtl/latched_sink_driver.sv
module latched_sink_driver
  import sink_drv_pkg::*;
#(
  parameter int unsigned NUM_DEV = 1
) (
  input  logic                         clk_i,
  input  logic                         rst_ni,
  input  logic                         sclk_i,
  input  logic                         rclk_i,
  input  logic                         ser_i,
  input  logic                         clr_ni,
  input  logic                         oe_ni,
  output logic                         ser_o,
  output logic [NUM_DEV*DEV_BITS-1:0]  drive_low_o,
  output logic [NUM_DEV*DEV_BITS-1:0]  hiz_o
);
  localparam int unsigned CHAIN_W = NUM_DEV * DEV_BITS;

  logic               shift_rise, load_rise;
  logic               chain_rst_n;
  logic [CHAIN_W-1:0] chain_q;
  logic [CHAIN_W-1:0] store_q;
  logic [NUM_DEV:0]   link;

  sink_drv_edge u_sclk_edge (
    .clk_i (clk_i), .rst_ni(rst_ni), .lvl_i(sclk_i), .rise_o(shift_rise)
  );
  sink_drv_edge u_rclk_edge (
    .clk_i (clk_i), .rst_ni(rst_ni), .lvl_i(rclk_i), .rise_o(load_rise)
  );

  // clear reaches the shift chain only
  assign chain_rst_n = rst_ni & clr_ni;
  assign link[0]     = ser_i;

  for (genvar d = 0; d < NUM_DEV; d++) begin : g_dev
    sink_drv_stage #(.W(DEV_BITS)) u_stage (
      .clk_i  (clk_i),
      .arst_ni(chain_rst_n),
      .shift_i(shift_rise),
      .ser_i  (link[d]),
      .q_o    (chain_q[d*DEV_BITS +: DEV_BITS]),
      .ser_o  (link[d+1])
    );
  end

  // same-cycle strobes: store samples the pre-shift chain
  sink_drv_store #(.W(CHAIN_W)) u_store (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .load_i(load_rise),
    .d_i   (chain_q),
    .q_o   (store_q)
  );

  for (genvar i = 0; i < CHAIN_W; i++) begin : g_pin
    assign drive_low_o[i] = store_q[i] & ~oe_ni;
    assign hiz_o[i]       = ~store_q[i] | oe_ni;
  end

  assign ser_o = link[NUM_DEV];
endmodule

// File: rtl/sink_drv_chk.sv
module sink_drv_chk #(
  parameter int unsigned W = 8
) (
  input logic         clk_i,
  input logic         rst_ni,
  input logic         sclk_i,
  input logic         rclk_i,
  input logic         ser_i,
  input logic         clr_ni,
  input logic         oe_ni,
  input logic         ser_o,
  input logic [W-1:0] drive_low_o,
  input logic [W-1:0] hiz_o,
  input logic [W-1:0] chain_i,
  input logic [W-1:0] store_i
);
  logic s_prev, r_prev;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      s_prev <= 1'b0;
      r_prev <= 1'b0;
    end else begin
      s_prev <= sclk_i;
      r_prev <= rclk_i;
    end
  end
  wire s_rise = sclk_i & ~s_prev;
  wire r_rise = rclk_i & ~r_prev;

  p_shift_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (s_rise && clr_ni) |=> (!clr_ni || chain_i == {$past(chain_i[W-2:0]), $past(ser_i)}));

  p_hold_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !s_rise |=> (!clr_ni || $stable(chain_i)));

  p_load_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    r_rise |=> store_i == $past(chain_i));

  p_keep_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !r_rise |=> $stable(store_i));

  p_disable_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    oe_ni |-> (drive_low_o == '0 && hiz_o == '1));

  p_clear_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !clr_ni |-> (chain_i == '0 && !ser_o));

  p_sense_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !oe_ni |-> (drive_low_o == store_i && hiz_o == ~store_i));
endmodule

bind latched_sink_driver sink_drv_chk #(.W(CHAIN_W)) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .sclk_i     (sclk_i),
  .rclk_i     (rclk_i),
  .ser_i      (ser_i),
  .clr_ni     (clr_ni),
  .oe_ni      (oe_ni),
  .ser_o      (ser_o),
  .drive_low_o(drive_low_o),
  .hiz_o      (hiz_o),
  .chain_i    (chain_q),
  .store_i    (store_q)
);

// File: tb/latched_sink_driver_tb.sv
module latched_sink_driver_tb;
  localparam int unsigned NDEV = 2;
  localparam int unsigned W    = NDEV * 8;

  logic clk_i = 1'b0;
  logic rst_ni, sclk_i, rclk_i, ser_i, clr_ni, oe_ni;
  logic ser_o;
  logic [W-1:0] drive_low_o, hiz_o;

  int checks = 0;
  int errors = 0;
  bit done   = 1'b0;

  always #2 clk_i = ~clk_i;

  latched_sink_driver #(.NUM_DEV(NDEV)) u_dut (
    .clk_i(clk_i), .rst_ni(rst_ni), .sclk_i(sclk_i), .rclk_i(rclk_i),
    .ser_i(ser_i), .clr_ni(clr_ni), .oe_ni(oe_ni), .ser_o(ser_o),
    .drive_low_o(drive_low_o), .hiz_o(hiz_o)
  );

  // bit 16 = oe_ni, bits 15:0 = word shifted in MSB first
  localparam logic [16:0] VEC [6] = '{
    {1'b0, 16'hA5C3}, {1'b0, 16'h0001}, {1'b0, 16'h8000},
    {1'b1, 16'hFFFF}, {1'b0, 16'h3C96}, {1'b0, 16'h0000}
  };

  task automatic chk(input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic shift_bit(input logic b);
    @(negedge clk_i); ser_i = b; sclk_i = 1'b1;
    @(negedge clk_i); sclk_i = 1'b0;
  endtask

  task automatic shift_word(input logic [W-1:0] w);
    for (int i = W - 1; i >= 0; i--) shift_bit(w[i]);
  endtask

  task automatic load();
    @(negedge clk_i); rclk_i = 1'b1;
    @(negedge clk_i); rclk_i = 1'b0;
  endtask

  task automatic chk_out(input string req, input logic [W-1:0] st, input logic dis);
    chk(req, drive_low_o, dis ? '0 : st);
    chk(req, hiz_o, dis ? '1 : ~st);
  endtask

  initial begin
    repeat (20000) @(posedge clk_i);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    rst_ni = 1'b0; sclk_i = 1'b0; rclk_i = 1'b0; ser_i = 1'b0;
    clr_ni = 1'b1; oe_ni = 1'b0;
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);
    // R9 reset state
    chk_out("R9", '0, 1'b0);
    chk("R9 ser_o", W'(ser_o), '0);

    // table walk: R1 R2 R5 R6 R3
    for (int v = 0; v < 6; v++) begin
      oe_ni = VEC[v][16];
      shift_word(VEC[v][15:0]);
      chk("R5 ser_o", W'(ser_o), W'(VEC[v][15]));
      load();
      chk_out("R1/R2/R6 table", VEC[v][15:0], VEC[v][16]);
    end
    oe_ni = 1'b0;
    @(negedge clk_i);
    // R3 data kept through disable (last was 0000, reload)
    shift_word(16'h5A0F); load();
    oe_ni = 1'b1; @(negedge clk_i);
    chk_out("R3 disabled", 16'h5A0F, 1'b1);
    oe_ni = 1'b0; @(negedge clk_i);
    chk_out("R3 restored", 16'h5A0F, 1'b0);

    // R2 outputs hold while shifting; R5 one more shift
    shift_word(16'hC001);
    chk_out("R2 hold during shift", 16'h5A0F, 1'b0);
    chk("R5 top bit", W'(ser_o), W'(1'b1));
    shift_bit(1'b0);
    chk("R5 after extra shift", W'(ser_o), W'(1'b1));
    shift_bit(1'b0);
    chk("R5 after 2nd extra shift", W'(ser_o), W'(1'b0));
    load();
    chk_out("R1 chain after extra shifts", 16'h0004, 1'b0);

    // R4 async clear, storage untouched
    shift_word(16'h8421);
    chk("R4 pre ser_o", W'(ser_o), W'(1'b1));
    #1 clr_ni = 1'b0;
    #0.5;
    chk("R4 async ser_o", W'(ser_o), '0);
    chk_out("R4 storage kept", 16'h0004, 1'b0);
    @(negedge clk_i); clr_ni = 1'b1;
    load();
    chk_out("R4 chain cleared", '0, 1'b0);

    // R8 strobes held high act once
    shift_word(16'h00F0);
    @(negedge clk_i); ser_i = 1'b1; sclk_i = 1'b1; rclk_i = 1'b0;
    repeat (4) @(negedge clk_i);
    sclk_i = 1'b0;
    @(negedge clk_i); rclk_i = 1'b1;
    repeat (3) @(negedge clk_i);
    chk_out("R8 single shift", 16'h01E1, 1'b0);
    shift_word(16'h7777);
    repeat (2) @(negedge clk_i);
    chk_out("R8 held load no reload", 16'h01E1, 1'b0);
    rclk_i = 1'b0;

    // R7 coincident strobes
    shift_word(16'h1234);
    @(negedge clk_i); ser_i = 1'b1; sclk_i = 1'b1; rclk_i = 1'b1;
    @(negedge clk_i); sclk_i = 1'b0; rclk_i = 1'b0;
    @(negedge clk_i);
    chk_out("R7 pre-shift value stored", 16'h1234, 1'b0);
    load();
    chk_out("R7 shifted chain", 16'h2469, 1'b0);

    // R9 reset mid-run
    @(negedge clk_i); rst_ni = 1'b0;
    @(negedge clk_i); rst_ni = 1'b1;
    @(negedge clk_i);
    chk_out("R9 re-reset", '0, 1'b0);
    chk("R9 ser_o re-reset", W'(ser_o), '0);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule